// File: doc/BRIEF.md
# Pointer-Redirected Byte Register File

This block is a small byte-wide store with two indirect access windows. Each window has its own pointer register. Address 00h is a window whose target is held in the first pointer, at 01h. Address 02h is a window whose target is held in the second pointer, at 03h. A CPU-side access to a window is redirected to the location its pointer holds. Every other address goes straight to the storage cell of that number.

The bus is a single port with address, write data, write enable and read enable. Read data is registered and appears one cycle after the read. A region-select input sends accesses through the second window to an external display memory instead of the local store. A display write leaves the address and data on dedicated outputs and raises a one-cycle write strobe. The first window always stays inside local memory.

A window whose pointer names a window address (00h or 02h) is a self-reference. Reading it yields zero and writing it changes nothing. Moving data directly from one window to the other is undefined, so software routes such moves through a general register such as the accumulator cell at 05h.

Top module: `irf_top`

## Requirements
- R1: A write to any address 04h or above stores the byte, and a later read of that address returns it. Read data appears on `rdData` at the clock edge after the edge that samples `rdEn`. A read in the same cycle as a write returns the contents from before the write.
- R2: An access to 00h reads or writes the location whose address is the first pointer's 7-bit value. An access to 02h does the same using the second pointer's 7-bit value.
- R3: When the pointer selected by a window access holds 00h or 02h, a read returns 00h.
- R4: When the pointer selected by a window access holds 00h or 02h, a write changes no storage cell and no pointer, and raises no display strobe, whatever the region select.
- R5: A write to 01h or 03h stores bits 6:0 of the write data in that pointer. A read of 01h or 03h returns the pointer with bit 7 forced to 1. After reset both pointers read 80h.
- R6: A window access whose pointer holds 01h or 03h reads or writes that pointer register, so one pointer can be loaded through the other window.
- R7: With `dispSel` high, a non-self-referencing write through 02h leaves local memory unchanged. One cycle later it pulses `dispWe` for exactly one cycle, with `dispAddr` equal to the second pointer and `dispData` equal to the written byte. A read through 02h with `dispSel` high returns 00h.
- R8: `dispSel` has no effect on direct accesses or on accesses through 00h; these never raise `dispWe`.
- R9: After reset `rdData` is 00h and `dispWe` is low. `rdData` holds its value through cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (7) | Bus address |
| wrData | input | DATA_W (8) | Bus write data |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| dispSel | input | 1 | Sends accesses through the second window to display memory |
| rdData | output | DATA_W (8) | Registered read data |
| dispWe | output | 1 | One-cycle display write strobe |
| dispAddr | output | ADDR_W (7) | Display write address |
| dispData | output | DATA_W (8) | Display write data |

## Verification
The hardest cases to reach are the chained ones. In one, a pointer is loaded through the other window. In another, a pointer is aimed at a window address while the region select is high, so that self-reference must take priority over the display route. The stimulus reaches these in steps. It first loads the first pointer with 03h and writes through 00h to set the second pointer. It then points the second pointer at 02h and writes through it with `dispSel` high. A scoreboard confirms that no strobe appears and that both pointers read back unchanged.

// File: rtl/irf_pkg.sv
package irf_pkg;

  typedef enum logic [1:0] {
    RD_RAM  = 2'd0,
    RD_PTR0 = 2'd1,
    RD_PTR1 = 2'd2,
    RD_ZERO = 2'd3
  } rdSrc_t;

  typedef struct packed {
    logic   ramWr;
    logic   ptr0Wr;
    logic   ptr1Wr;
    logic   dispWr;
    logic   rdEn;
    rdSrc_t rdSrc;
  } irfStrobe_t;

endpackage

// File: rtl/irf_ctrl.sv
module irf_ctrl
  import irf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dispSel,
  input  logic [ADDR_W-1:0] mp0Val,
  input  logic [ADDR_W-1:0] mp1Val,
  output irfStrobe_t        stb,
  output logic [ADDR_W-1:0] tgtAddr
);

  localparam logic [ADDR_W-1:0] WIN0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PTR0 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WIN1 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PTR1 = ADDR_W'(3);

  logic viaWin0, viaWin1, selfRef, toDisp;

  always_comb begin
    viaWin0 = (addr == WIN0);
    viaWin1 = (addr == WIN1);
    if (viaWin0)      tgtAddr = mp0Val;
    else if (viaWin1) tgtAddr = mp1Val;
    else              tgtAddr = addr;
    selfRef = (viaWin0 || viaWin1) && ((tgtAddr == WIN0) || (tgtAddr == WIN1));
    toDisp  = viaWin1 && dispSel && !selfRef;
  end

  always_comb begin
    stb        = '0;
    stb.rdEn   = rdEn;
    stb.rdSrc  = RD_RAM;
    if (selfRef || toDisp)      stb.rdSrc = RD_ZERO;
    else if (tgtAddr == PTR0)   stb.rdSrc = RD_PTR0;
    else if (tgtAddr == PTR1)   stb.rdSrc = RD_PTR1;
    if (wrEn && !selfRef) begin
      if (toDisp)                stb.dispWr = 1'b1;
      else if (tgtAddr == PTR0)  stb.ptr0Wr = 1'b1;
      else if (tgtAddr == PTR1)  stb.ptr1Wr = 1'b1;
      else                       stb.ramWr  = 1'b1;
    end
  end

endmodule

// File: rtl/irf_datapath.sv
module irf_datapath
  import irf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irfStrobe_t        stb,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] mp0Val,
  output logic [ADDR_W-1:0] mp1Val,
  output logic [DATA_W-1:0] rdData,
  output logic              dispWe,
  output logic [ADDR_W-1:0] dispAddr,
  output logic [DATA_W-1:0] dispData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPTR  = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptrReg [NPTR];
  logic [NPTR-1:0]   ptrWr;

  assign ptrWr  = {stb.ptr1Wr, stb.ptr0Wr};
  assign mp0Val = ptrReg[0];
  assign mp1Val = ptrReg[1];

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         ptrReg[i] <= '0;
      else if (ptrWr[i]) ptrReg[i] <= wrData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.ramWr) mem[tgtAddr] <= wrData;
  end

  function automatic logic [DATA_W-1:0] ptrView(input logic [ADDR_W-1:0] p);
    logic [DATA_W-1:0] v;
    v = '0;
    v[ADDR_W-1:0] = p;
    v[DATA_W-1] = 1'b1;
    return v;
  endfunction

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    unique case (stb.rdSrc)
      RD_RAM:  rdNext = mem[tgtAddr];
      RD_PTR0: rdNext = ptrView(ptrReg[0]);
      RD_PTR1: rdNext = ptrView(ptrReg[1]);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      dispWe   <= 1'b0;
      dispAddr <= '0;
      dispData <= '0;
    end else begin
      if (stb.rdEn) rdData <= rdNext;
      dispWe <= stb.dispWr;
      if (stb.dispWr) begin
        dispAddr <= tgtAddr;
        dispData <= wrData;
      end
    end
  end

endmodule

// File: rtl/irf_top.sv
module irf_top
  import irf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dispSel,
  output logic [DATA_W-1:0] rdData,
  output logic              dispWe,
  output logic [ADDR_W-1:0] dispAddr,
  output logic [DATA_W-1:0] dispData
);

  irfStrobe_t        stb;
  logic [ADDR_W-1:0] tgtAddr;
  logic [ADDR_W-1:0] mp0Val, mp1Val;

  irf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .dispSel(dispSel),
    .mp0Val(mp0Val), .mp1Val(mp1Val), .stb(stb), .tgtAddr(tgtAddr)
  );

  irf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtAddr(tgtAddr), .wrData(wrData),
    .mp0Val(mp0Val), .mp1Val(mp1Val), .rdData(rdData),
    .dispWe(dispWe), .dispAddr(dispAddr), .dispData(dispData)
  );

endmodule

// File: rtl/irf_checker.sv
module irf_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic              rdEn,
  input logic              dispSel,
  input logic [DATA_W-1:0] rdData,
  input logic              dispWe,
  input logic [DATA_W-1:0] dispData,
  input logic [ADDR_W-1:0] mp0Val,
  input logic [ADDR_W-1:0] mp1Val
);

  logic win0Self, win1Self;
  assign win0Self = (addr == ADDR_W'(0)) && (mp0Val == ADDR_W'(0) || mp0Val == ADDR_W'(2));
  assign win1Self = (addr == ADDR_W'(2)) && (mp1Val == ADDR_W'(0) || mp1Val == ADDR_W'(2));

  p_self_read_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (win0Self || win1Self) |=> rdData == '0);

  p_self_write_noop_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (win0Self || win1Self) |=> $stable(mp0Val) && $stable(mp1Val) && !dispWe);

  p_ptr_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (addr == ADDR_W'(1) || addr == ADDR_W'(3)) |=> rdData[DATA_W-1]);

  p_disp_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_W'(2) && dispSel && !win1Self |=> dispWe && dispData == $past(wrData));

  p_disp_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    dispWe |-> $past(wrEn && addr == ADDR_W'(2) && dispSel));

  p_disp_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    dispWe && !(wrEn && addr == ADDR_W'(2) && dispSel) |=> !dispWe);

endmodule

bind irf_top irf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .dispSel(dispSel), .rdData(rdData), .dispWe(dispWe),
  .dispData(dispData), .mp0Val(mp0Val), .mp1Val(mp1Val)
);

// File: tb/irf_top_test.sv
module irf_top_test;

  localparam int AW = 7;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic          dispSel = 1'b0;
  logic [DW-1:0] rdData;
  logic          dispWe;
  logic [AW-1:0] dispAddr;
  logic [DW-1:0] dispData;

  irf_top #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .dispSel(dispSel), .rdData(rdData), .dispWe(dispWe),
    .dispAddr(dispAddr), .dispData(dispData)
  );

  always #5 clk = ~clk;

  typedef struct { logic [DW-1:0] d; string tag; } rdItem_t;
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } dispItem_t;

  rdItem_t   rdQ[$];
  dispItem_t dispQ[$];
  int nCmp = 0;
  int nBad = 0;
  logic pendRd = 1'b0;
  logic monOn = 1'b0;
  logic [DW-1:0] lastRd = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pendRd <= rdEn && rstN;

  always @(negedge clk) begin
    if (monOn && pendRd) begin
      if (rdQ.size() == 0) check(1'b0, "R1 unexpected read", 32'(rdData), 0);
      else begin
        rdItem_t it;
        it = rdQ.pop_front();
        check(rdData == it.d, it.tag, 32'(rdData), 32'(it.d));
        lastRd = it.d;
      end
    end
    if (monOn && dispWe) begin
      if (dispQ.size() == 0) check(1'b0, "R8 unexpected dispWe", 1, 0);
      else begin
        dispItem_t di;
        di = dispQ.pop_front();
        check(dispAddr == di.a, "R7 dispAddr", 32'(dispAddr), 32'(di.a));
        check(dispData == di.d, "R7 dispData", 32'(dispData), 32'(di.d));
      end
    end
  end

  task automatic op(input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d,
                    input bit r, input logic [DW-1:0] e, input bit ds, input string tag);
    addr = a; wrData = d; wrEn = w; rdEn = r; dispSel = ds;
    if (r) rdQ.push_back('{d: e, tag: tag});
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; dispSel = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ds);
    op(a, 1'b1, d, 1'b0, '0, ds, "");
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input bit ds, input string tag);
    op(a, 1'b0, '0, 1'b1, e, ds, tag);
  endtask

  bit finished = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdData == 8'h00, "R9 reset rdData", 32'(rdData), 0);
    check(dispWe == 1'b0, "R9 reset dispWe", 32'(dispWe), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);

    rd(7'h01, 8'h80, 0, "R5 mp0 reset");
    rd(7'h03, 8'h80, 0, "R5 mp1 reset");
    rd(7'h00, 8'h00, 0, "R3 self read at reset");
    wr(7'h00, 8'h55, 0);
    rd(7'h01, 8'h80, 0, "R4 mp0 unchanged");
    rd(7'h03, 8'h80, 0, "R4 mp1 unchanged");

    wr(7'h10, 8'hA5, 0);
    rd(7'h10, 8'hA5, 0, "R1 direct");
    wr(7'h01, 8'hFF, 0);
    rd(7'h01, 8'hFF, 0, "R5 msb forced");
    wr(7'h01, 8'h10, 0);
    rd(7'h01, 8'h90, 0, "R5 readback");
    rd(7'h00, 8'hA5, 0, "R2 window0 read");
    wr(7'h00, 8'h3C, 0);
    rd(7'h10, 8'h3C, 0, "R2 window0 write");
    wr(7'h03, 8'h20, 0);
    wr(7'h02, 8'h77, 0);
    rd(7'h20, 8'h77, 0, "R2 window1 write");
    rd(7'h02, 8'h77, 0, "R2 window1 read");

    wr(7'h01, 8'h03, 0);
    wr(7'h00, 8'h10, 0);
    rd(7'h03, 8'h90, 0, "R6 mp1 loaded via window0");
    rd(7'h00, 8'h90, 0, "R6 pointer read via window0");

    wr(7'h03, 8'h02, 0);
    rd(7'h02, 8'h00, 0, "R3 self read window1");
    wr(7'h02, 8'h99, 0);
    wr(7'h02, 8'h44, 1);
    rd(7'h03, 8'h82, 0, "R4 mp1 unchanged");
    rd(7'h01, 8'h83, 0, "R4 mp0 unchanged");
    wr(7'h01, 8'h02, 0);
    rd(7'h00, 8'h00, 0, "R3 self read window0 at 02h");

    wr(7'h03, 8'h20, 1);
    rd(7'h03, 8'hA0, 1, "R8 direct ignores dispSel");
    dispQ.push_back('{a: 7'h20, d: 8'hC3});
    wr(7'h02, 8'hC3, 1);
    rd(7'h02, 8'h00, 1, "R7 display read zero");
    rd(7'h20, 8'h77, 0, "R7 RAM untouched");

    wr(7'h01, 8'h10, 1);
    wr(7'h00, 8'h5A, 1);
    rd(7'h10, 8'h5A, 0, "R8 window0 ignores dispSel");
    wr(7'h30, 8'h11, 1);
    rd(7'h30, 8'h11, 1, "R8 direct write ignores dispSel");

    op(7'h10, 1'b1, 8'hEE, 1'b1, 8'h5A, 0, "R1 read before write");
    rd(7'h10, 8'hEE, 0, "R1 after write");
    repeat (3) @(negedge clk);
    check(rdData == lastRd, "R9 rdData holds", 32'(rdData), 32'(lastRd));

    repeat (2) @(negedge clk);
    check(rdQ.size() == 0, "R1 reads outstanding", rdQ.size(), 0);
    check(dispQ.size() == 0, "R7 strobe missing", dispQ.size(), 0);
    finish_run();
  end

endmodule